// File: doc/BRIEF.md
# Four-Channel Hysteretic Signal Detector with Squelch

This block watches four serial lanes and reports, per lane, whether a usable signal is present. Each lane receives an integer peak-to-peak amplitude sample in millivolts on every clock. The block compares it against two separate limits: a higher "turn on" limit and a lower "turn off" limit. Each limit is picked from a fixed four-entry table by a 2-bit code. The gap between the two limits gives hysteresis, so a lane that sits between them keeps its present state.

Detection reacts in two asymmetric ways. Declaring a signal present takes a short run of qualifying samples. Declaring it lost takes a much longer run. The count is held in clock cycles set by parameters, and it starts over whenever a sample fails to qualify. The detect flag drives a per-lane output mute for idle periods, which can be turned off globally so that out-of-band bursts pass. It also drives an optional automatic power-down that keeps a quiet lane in standby.

Top module: `sig_detect_quad`

## Requirements
- R1: The turn-on limit for a lane is chosen by its 2-bit code as follows: 2'b00 gives 130 mV, 2'b01 gives 125 mV, 2'b10 gives 150 mV and 2'b11 gives 140 mV.
- R2: The turn-off limit for a lane is chosen by its 2-bit code as follows: 2'b00 gives 60 mV, 2'b01 gives 40 mV, 2'b10 gives 105 mV and 2'b11 gives 90 mV.
- R3: In both code inputs, lane n takes its code from bits [2n+1:2n], so lane 0 uses bits 1:0 and lane 3 uses bits 7:6.
- R4: A lane whose flag is low raises it on the clock edge that ends ON_DLY (default 4) consecutive enabled cycles with the amplitude strictly above the turn-on limit. An amplitude equal to the limit does not qualify.
- R5: A lane whose flag is high drops it on the clock edge that ends OFF_DLY (default 16) consecutive enabled cycles with the amplitude strictly below the turn-off limit. An amplitude equal to the limit does not qualify.
- R6: While the amplitude fails to qualify for the opposite state, the flag holds. A single non-qualifying cycle restarts the count from zero.
- R7: With `oob_pass_i` low, `mute_o[n]` is the inverse of `sig_det_o[n]`. With `oob_pass_i` high, every `mute_o` bit is 0.
- R8: A low `lane_en_i[n]` clears lane n's flag on the next edge and discards any partial count. After re-enabling, a full ON_DLY run is needed again.
- R9: With `auto_sleep_i` low, `lane_on_o` equals `lane_en_i`. With it high, `lane_on_o[n]` is `lane_en_i[n]` AND `sig_det_o[n]`.
- R10: During reset all flags and counts are zero, so `mute_o` is all ones while `oob_pass_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_i | input | NUM_LANES*AMP_W | Per-lane amplitude in mV, lane n at [n*AMP_W +: AMP_W] |
| on_code_i | input | 2*NUM_LANES | Turn-on limit codes, 2 bits per lane |
| off_code_i | input | 2*NUM_LANES | Turn-off limit codes, 2 bits per lane |
| oob_pass_i | input | 1 | 1 disables muting for all lanes |
| auto_sleep_i | input | 1 | 1 gates each lane's enable with its detect flag |
| lane_en_i | input | NUM_LANES | Per-lane enable |
| sig_det_o | output | NUM_LANES | Registered signal-present flag per lane |
| mute_o | output | NUM_LANES | Driver mute request per lane |
| lane_on_o | output | NUM_LANES | Effective lane enable |

## Verification
A wrong cycle count shows on `sig_det_o` within one edge of the expected change. It appears as a rise or fall that is one or more edges early or late, or as a rise after an interrupted run that should have restarted. A wrong limit decode or a misplaced code field makes the lanes change state in the wrong order when the amplitude is swept past the four limits. A partial count that survives a disable makes the flag rise in fewer than ON_DLY cycles after re-enable. The mute and effective-enable outputs follow the flag within the same cycle, so any flag error also shows on them at once.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;

    function automatic int unsigned on_limit_mv(input logic [1:0] code);
        case (code)
            2'b00:   on_limit_mv = 130;
            2'b01:   on_limit_mv = 125;
            2'b10:   on_limit_mv = 150;
            default: on_limit_mv = 140;
        endcase
    endfunction

    function automatic int unsigned off_limit_mv(input logic [1:0] code);
        case (code)
            2'b00:   off_limit_mv = 60;
            2'b01:   off_limit_mv = 40;
            2'b10:   off_limit_mv = 105;
            default: off_limit_mv = 90;
        endcase
    endfunction

endpackage

// File: rtl/sigdet_limits.sv
module sigdet_limits #(
    parameter int AMP_W = 10
) (
    input  logic [1:0]       on_code_i,
    input  logic [1:0]       off_code_i,
    output logic [AMP_W-1:0] on_mv_o,
    output logic [AMP_W-1:0] off_mv_o
);
    import sigdet_pkg::*;

    always_comb begin
        on_mv_o  = AMP_W'(on_limit_mv(on_code_i));
        off_mv_o = AMP_W'(off_limit_mv(off_code_i));
    end

endmodule

// File: rtl/sigdet_lane.sv
module sigdet_lane #(
    parameter int AMP_W   = 10,
    parameter int ON_DLY  = 4,
    parameter int OFF_DLY = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [AMP_W-1:0] amp_i,
    input  logic [AMP_W-1:0] on_mv_i,
    input  logic [AMP_W-1:0] off_mv_i,
    output logic             det_o
);
    localparam int MAX_DLY = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_DLY - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_DLY - 1);

    typedef struct packed {
        logic             det;
        logic [CNT_W-1:0] run;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     qualify;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d    = st_q;
        qualify = st_q.det ? (amp_i < off_mv_i) : (amp_i > on_mv_i);
        last    = st_q.det ? OFF_LAST : ON_LAST;
        if (!en_i) begin
            st_d.det = 1'b0;
            st_d.run = '0;
        end else if (!qualify) begin
            st_d.run = '0;
        end else if (st_q.run == last) begin
            st_d.det = ~st_q.det;
            st_d.run = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign det_o = st_q.det;

    // R4: a rise is always preceded by an amplitude above the turn-on limit
    a_r4_rise_above: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.det) |-> $past(en_i && (amp_i > on_mv_i)));

    // R5: a fall while enabled is preceded by an amplitude below the turn-off limit
    a_r5_fall_below: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.det) && $past(en_i)) |-> $past(amp_i < off_mv_i));

    // R8: disabling clears both the flag and the partial run
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!st_q.det && (st_q.run == '0)));

    generate
        if (ON_DLY > 1) begin : g_min_run
            // R6: with a multi-cycle window, one qualifying cycle never suffices
            a_r6_no_single_cycle_rise: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.det) |-> $past(amp_i > on_mv_i, 2));
        end
    endgenerate

endmodule

// File: rtl/sig_detect_quad.sv
module sig_detect_quad #(
    parameter int NUM_LANES = 4,
    parameter int AMP_W     = 10,
    parameter int ON_DLY    = 4,
    parameter int OFF_DLY   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LANES*AMP_W-1:0] amp_i,
    input  logic [2*NUM_LANES-1:0]     on_code_i,
    input  logic [2*NUM_LANES-1:0]     off_code_i,
    input  logic                       oob_pass_i,
    input  logic                       auto_sleep_i,
    input  logic [NUM_LANES-1:0]       lane_en_i,
    output logic [NUM_LANES-1:0]       sig_det_o,
    output logic [NUM_LANES-1:0]       mute_o,
    output logic [NUM_LANES-1:0]       lane_on_o
);

    generate
        for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
            logic [AMP_W-1:0] on_mv, off_mv;

            sigdet_limits #(.AMP_W(AMP_W)) i_limits (
                .on_code_i  (on_code_i[2*n +: 2]),
                .off_code_i (off_code_i[2*n +: 2]),
                .on_mv_o    (on_mv),
                .off_mv_o   (off_mv)
            );

            sigdet_lane #(
                .AMP_W   (AMP_W),
                .ON_DLY  (ON_DLY),
                .OFF_DLY (OFF_DLY)
            ) i_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .en_i     (lane_en_i[n]),
                .amp_i    (amp_i[n*AMP_W +: AMP_W]),
                .on_mv_i  (on_mv),
                .off_mv_i (off_mv),
                .det_o    (sig_det_o[n])
            );

            always_comb begin
                mute_o[n]    = !oob_pass_i && !sig_det_o[n];
                lane_on_o[n] = lane_en_i[n] && (!auto_sleep_i || sig_det_o[n]);
            end

            // R9: an effective enable never appears on a lane that is switched off
            a_r9_on_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
                lane_on_o[n] |-> lane_en_i[n]);
        end
    endgenerate

endmodule

// File: tb/test_sig_detect_quad.sv
`timescale 1ns/100ps
module test_sig_detect_quad;

    localparam int NL = 4;
    localparam int AW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL*AW-1:0] amp;
    logic [7:0]      on_code, off_code;
    logic            oob_pass, auto_sleep;
    logic [3:0]      lane_en;
    logic [3:0]      sig_det, mute, lane_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sig_detect_quad i_sig_detect_quad (
        .clk          (clk),
        .rst_n        (rst_n),
        .amp_i        (amp),
        .on_code_i    (on_code),
        .off_code_i   (off_code),
        .oob_pass_i   (oob_pass),
        .auto_sleep_i (auto_sleep),
        .lane_en_i    (lane_en),
        .sig_det_o    (sig_det),
        .mute_o       (mute),
        .lane_on_o    (lane_on)
    );

    typedef struct packed {
        logic [9:0] mv;
        logic [7:0] cycles;
        logic       det;
    } vec_t;

    // codes 00: on 130, off 60; ON_DLY 4, OFF_DLY 16
    localparam vec_t VECS [15] = '{
        '{10'd200, 8'd3,  1'b0},  // R4 one short of window
        '{10'd200, 8'd1,  1'b1},  // R4 rises on 4th edge
        '{10'd100, 8'd20, 1'b1},  // R6 between limits holds
        '{10'd50,  8'd15, 1'b1},  // R5 one short
        '{10'd50,  8'd1,  1'b0},  // R5 falls on 16th edge
        '{10'd130, 8'd10, 1'b0},  // R4 equal does not qualify
        '{10'd131, 8'd3,  1'b0},
        '{10'd100, 8'd1,  1'b0},  // R6 break
        '{10'd131, 8'd3,  1'b0},  // R6 restarted
        '{10'd131, 8'd1,  1'b1},
        '{10'd60,  8'd20, 1'b1},  // R5 equal does not qualify
        '{10'd59,  8'd10, 1'b1},
        '{10'd61,  8'd1,  1'b1},  // R6 break
        '{10'd59,  8'd15, 1'b1},
        '{10'd59,  8'd1,  1'b0}
    };

    task automatic put_amp(input logic [9:0] v);
        amp = {NL{v}};
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        put_amp(10'd0);
        on_code = 8'h00; off_code = 8'h00;
        oob_pass = 1'b0; auto_sleep = 1'b0; lane_en = 4'hF;
        run(3);
        chk("R10 det in reset", sig_det, 4'h0);
        chk("R10 mute in reset", mute, 4'hF);
        chk("R9 lane_on follows enable", lane_on, 4'hF);
        rst_n = 1'b1;
        run(1);

        // R4 R5 R6 R7 vector walk
        foreach (VECS[i]) begin
            put_amp(VECS[i].mv);
            run(int'(VECS[i].cycles));
            chk($sformatf("R4/R5/R6 vector %0d det", i), sig_det, {NL{VECS[i].det}});
            chk($sformatf("R7 vector %0d mute", i), mute, {NL{~VECS[i].det}});
        end

        // R1 R3: on codes lane0=01(125) lane1=00(130) lane2=11(140) lane3=10(150)
        on_code = 8'b10_11_00_01;
        off_code = 8'b10_11_00_01; // R2: 40, 60, 90, 105
        put_amp(10'd126); run(4); chk("R1 R3 above 125", sig_det, 4'b0001);
        put_amp(10'd135); run(4); chk("R1 R3 above 130", sig_det, 4'b0011);
        put_amp(10'd145); run(4); chk("R1 R3 above 140", sig_det, 4'b0111);
        put_amp(10'd151); run(4); chk("R1 R3 above 150", sig_det, 4'b1111);

        // R2 R3: sweep down past turn-off limits
        put_amp(10'd100); run(16); chk("R2 R3 below 105", sig_det, 4'b0111);
        put_amp(10'd85);  run(16); chk("R2 R3 below 90",  sig_det, 4'b0011);
        put_amp(10'd55);  run(16); chk("R2 R3 below 60",  sig_det, 4'b0001);
        put_amp(10'd39);  run(16); chk("R2 R3 below 40",  sig_det, 4'b0000);

        // R8: partial run is discarded by a disable
        on_code = 8'h00; off_code = 8'h00;
        put_amp(10'd200); run(3);
        lane_en = 4'b1011; run(1);
        chk("R8 disabled lane stays low", sig_det, 4'b1011);
        lane_en = 4'hF; run(1);
        chk("R8 partial run discarded", sig_det, 4'b1011);
        run(3);
        chk("R8 full window after re-enable", sig_det, 4'hF);
        lane_en = 4'b1101; run(1);
        chk("R8 disable forces flag low", sig_det, 4'b1101);
        chk("R9 lane_on with enable low", lane_on, 4'b1101);
        lane_en = 4'hF; run(1);
        chk("R8 not yet re-detected", sig_det, 4'b1101);

        // R9 R7: combinational controls, no clock edge in between
        auto_sleep = 1'b1; #0.5;
        chk("R9 auto sleep gates quiet lane", lane_on, 4'b1101);
        oob_pass = 1'b1; #0.5;
        chk("R7 pass mode never mutes", mute, 4'b0000);
        oob_pass = 1'b0; #0.5;
        chk("R7 quiet lane muted", mute, 4'b0010);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule